// File: doc/BRIEF.md
# Heartbeat Pulse Output for a Processing Core

This block produces a slow square-wave heartbeat on an open-drain pin so that an outside controller can see whether the processing core is alive. The pin is either pulled low or released. It changes state once per programmed interval, counted in whole milliseconds from a one-cycle millisecond tick. The interval is set by a command write of 0 to 100 ms. After reset the interval is 100 ms, and an interval of 0 turns the heartbeat off.

The heartbeat advances only while the core is running normal processing. When the core takes its audio clocks from outside (slave mode), the heartbeat also needs audio frames to arrive. The frame clock counts as missing once two millisecond ticks pass with no frame edge. Whenever a condition for running fails, the pin is released at once and the interval count starts over.

All inputs are plain control strobes and levels. There is no streaming data path, so no valid/ready handshake or back-pressure applies. A period write is taken in the cycle its strobe is high.

Top module: `hb_heartbeat`

## Requirements
- R1: After reset `hb_pull_low` is 0 and the interval is 100 ms. With processing enabled in master mode, the pin stays released for ticks 1 to 99 and is pulled low at tick 100.
- R2: While the block is active with interval P (1..100), the pin level after k counted ticks is low (`hb_pull_low`=1) exactly when floor(k/P) is odd. The count k starts at zero from the last restart.
- R3: A written value above 100 is stored as 100.
- R4: With interval 0 the pin stays released whatever ticks arrive.
- R5: A period write clears the count and releases the pin from the next cycle. A tick in the same cycle as the write is not counted.
- R6: When `proc_run` is low the pin is released in that same cycle and no ticks are counted. Counting restarts from zero when `proc_run` returns high.
- R7: In slave mode (`slave_mode`=1) the heartbeat runs only while the frame clock is present. In master mode, frame edges are ignored.
- R8: A `frame_edge` pulse marks the frame clock present from the next cycle. The clock is marked absent at the second millisecond tick with no edge in between, and that tick still counts. At reset the frame clock is absent.
- R9: The internal pin level changes only on a cycle that follows a tick, a write, or an inactive cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| frame_edge | input | 1 | One-cycle pulse on each observed frame-clock edge |
| slave_mode | input | 1 | 1: audio clocks come from outside, so frame presence is required |
| proc_run | input | 1 | 1: normal processing is active |
| period_wr | input | 1 | Strobe: write a new interval |
| period_wdata | input | 7 | Interval in ms, 0..100; larger values saturate |
| hb_pull_low | output | 1 | Open-drain enable: 1 pulls the pin low, 0 releases it |

## Verification
Ticks, writes and frame edges are registered effects. Their result is visible after the single rising edge that samples them. The bench drives every input on a falling edge and reads `hb_pull_low` at the next falling edge. The release on `proc_run` low is combinational, so it is read a nanosecond after the input changes, before any clock edge. Expected levels come from the floor(k/P) parity rule, with k counted in the bench from each restart, across a sweep of every interval from 1 to 8 and the default of 100.

// File: rtl/hb_pkg.sv
package hb_pkg;
  // Saturate a requested interval to the supported maximum.
  function automatic int unsigned hb_sat(input int unsigned req, input int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction
endpackage

// File: rtl/hb_frame_mon.sv
module hb_frame_mon #(
  parameter int unsigned ABSENT_MS = 2,
  localparam int unsigned GAP_W = (ABSENT_MS < 2) ? 1 : $clog2(ABSENT_MS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic frame_edge,
  output logic present
);
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present <= 1'b0;
      gap     <= '0;
    end else if (frame_edge) begin
      present <= 1'b1;
      gap     <= '0;
    end else if (ms_tick && present) begin
      if (gap == GAP_W'(ABSENT_MS - 1)) begin
        present <= 1'b0;
        gap     <= '0;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hb_period_reg.sv
module hb_period_reg #(
  parameter int unsigned W    = 7,
  parameter int unsigned MAXP = 100,
  parameter int unsigned DEFP = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] period
);
  import hb_pkg::*;

  logic [W-1:0] sat_val;
  assign sat_val = W'(hb_sat(int'(wdata), MAXP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  period <= W'(hb_sat(DEFP, MAXP));
    else if (wr) period <= sat_val;
  end
endmodule

// File: rtl/hb_interval.sv
module hb_interval #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         restart,
  input  logic         ms_tick,
  input  logic [W-1:0] period,
  output logic         phase
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (restart || !enable) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (ms_tick) begin
      if (cnt == period - 1'b1) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hb_heartbeat.sv
module hb_heartbeat #(
  parameter int unsigned MAX_PERIOD_MS     = 100,
  parameter int unsigned DEFAULT_PERIOD_MS = 100,
  parameter int unsigned ABSENT_MS         = 2,
  localparam int unsigned PERIOD_W = $clog2(MAX_PERIOD_MS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ms_tick,
  input  logic                frame_edge,
  input  logic                slave_mode,
  input  logic                proc_run,
  input  logic                period_wr,
  input  logic [PERIOD_W-1:0] period_wdata,
  output logic                hb_pull_low
);
  logic [PERIOD_W-1:0] period_q;
  logic                present_q;
  logic                phase_q;
  logic                active;

  hb_period_reg #(.W(PERIOD_W), .MAXP(MAX_PERIOD_MS), .DEFP(DEFAULT_PERIOD_MS)) u_per (
    .clk(clk), .rst_n(rst_n), .wr(period_wr), .wdata(period_wdata), .period(period_q)
  );

  hb_frame_mon #(.ABSENT_MS(ABSENT_MS)) u_mon (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .frame_edge(frame_edge), .present(present_q)
  );

  assign active = proc_run && (period_q != '0) && (!slave_mode || present_q);

  hb_interval #(.W(PERIOD_W)) u_int (
    .clk(clk), .rst_n(rst_n), .enable(active), .restart(period_wr),
    .ms_tick(ms_tick), .period(period_q), .phase(phase_q)
  );

  assign hb_pull_low = phase_q & active;
endmodule

// File: rtl/hb_heartbeat_chk.sv
module hb_heartbeat_chk #(
  parameter int unsigned W    = 7,
  parameter int unsigned MAXP = 100
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ms_tick,
  input logic         frame_edge,
  input logic         slave_mode,
  input logic         proc_run,
  input logic         period_wr,
  input logic         hb_pull_low,
  input logic [W-1:0] period_q,
  input logic         present_q,
  input logic         phase_q,
  input logic         active
);
  a_r3_period_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    period_q <= W'(MAXP));

  a_r4_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q == '0) |-> !hb_pull_low);

  a_r5_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    period_wr |=> !phase_q);

  a_r6_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_run |=> !phase_q);

  a_r7_absent_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && !present_q) |-> !hb_pull_low);

  a_r8_edge_presence: assert property (@(posedge clk) disable iff (!rst_n)
    frame_edge |=> present_q);

  a_r9_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_q) |-> ($past(ms_tick) || $past(period_wr) || !$past(active)));
endmodule

bind hb_heartbeat hb_heartbeat_chk #(.W(PERIOD_W), .MAXP(MAX_PERIOD_MS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .frame_edge(frame_edge),
  .slave_mode(slave_mode), .proc_run(proc_run), .period_wr(period_wr),
  .hb_pull_low(hb_pull_low), .period_q(period_q), .present_q(present_q),
  .phase_q(phase_q), .active(active)
);

// File: tb/hb_heartbeat_test.sv
`timescale 1ns/1ps
module hb_heartbeat_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       frame_edge = 1'b0;
  logic       slave_mode = 1'b0;
  logic       proc_run = 1'b0;
  logic       period_wr = 1'b0;
  logic [6:0] period_wdata = '0;
  logic       hb_pull_low;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hb_heartbeat uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .frame_edge(frame_edge),
    .slave_mode(slave_mode), .proc_run(proc_run), .period_wr(period_wr),
    .period_wdata(period_wdata), .hb_pull_low(hb_pull_low)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: hb_pull_low=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  task automatic edge_pulse();
    frame_edge = 1'b1;
    @(negedge clk);
    frame_edge = 1'b0;
  endtask

  task automatic write_period(input int v);
    period_wr = 1'b1;
    period_wdata = 7'(v);
    @(negedge clk);
    period_wr = 1'b0;
  endtask

  // Fresh count assumed: after k ticks the pin is low when floor(k/p) is odd.
  task automatic sweep(input int p, input int n, input string tag);
    for (int k = 1; k <= n; k++) begin
      tick();
      check(tag, hb_pull_low, ((k / p) % 2) == 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: hb_pull_low=%0b expected run to end", hb_pull_low);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", hb_pull_low, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    proc_run = 1'b1;
    @(negedge clk);
    check("R1", hb_pull_low, 1'b0);
    // R1 default 100 ms interval; R7 master mode runs with no frame edges
    sweep(100, 201, "R1");

    // R2 every interval 1..8
    for (int p = 1; p <= 8; p++) begin
      write_period(p);
      check("R2", hb_pull_low, 1'b0);
      sweep(p, 4 * p + 1, "R2");
    end

    // R3 saturation
    write_period(127);
    sweep(100, 101, "R3");
    write_period(101);
    sweep(100, 100, "R3");

    // R4 zero interval
    write_period(0);
    for (int i = 0; i < 20; i++) begin
      tick();
      check("R4", hb_pull_low, 1'b0);
    end

    // R5 restart on write, tick in same cycle ignored
    write_period(3);
    sweep(3, 4, "R5");
    write_period(3);
    check("R5", hb_pull_low, 1'b0);
    sweep(3, 4, "R5");
    ms_tick = 1'b1;
    write_period(3);
    ms_tick = 1'b0;
    check("R5", hb_pull_low, 1'b0);
    sweep(3, 7, "R5");

    // R6 halt
    write_period(3);
    sweep(3, 3, "R6");
    proc_run = 1'b0;
    #1;
    check("R6", hb_pull_low, 1'b0);
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R6", hb_pull_low, 1'b0);
    end
    proc_run = 1'b1;
    @(negedge clk);
    sweep(3, 7, "R6");

    // R7 slave mode with no frame clock since reset
    write_period(1);
    slave_mode = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R7", hb_pull_low, 1'b0);
    end
    // R8 frame edges make it present; heartbeat resumes from zero
    for (int k = 1; k <= 7; k++) begin
      edge_pulse();
      tick();
      check("R8", hb_pull_low, (k % 2) == 1);
    end
    // R8 edges stop: first tick still counts (k=8 -> released), second marks absent
    tick();
    check("R8", hb_pull_low, 1'b0);
    tick();
    check("R8", hb_pull_low, 1'b0);
    tick();
    check("R7", hb_pull_low, 1'b0);
    tick();
    check("R7", hb_pull_low, 1'b0);
    // R7 master mode ignores frame absence
    slave_mode = 1'b0;
    @(negedge clk);
    write_period(1);
    sweep(1, 4, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule